// File: doc/BRIEF.md
# Quad Down-Counting Timer Unit

This block holds four independent down-counters behind a small 32-bit word-addressed register port, plus one shared set of interrupt registers. Each counter decrements on prescaled pulses of a tick-enable input and can run in one of three modes:

- one-shot, where it stops after reaching zero;
- periodic, where it reloads from a reload register;
- free-running, where it wraps to all ones.

Writes to the primary load register restart the count. Writes to the background-load register only change what the next wrap reloads. Because the counters count down, software that wants an up-counting time base reads a counter and inverts it.

Any counter that reaches zero sets its bit in a raw interrupt status register. A mask selects which raw bits drive the single combined interrupt output. Each raw bit stays set until software clears it by writing a one to the matching bit of the clear register. Everything runs on one clock. Reads are combinational from the addressed register and writes take effect at the next clock edge.

Top module: `quad_dtimer`

## Requirements
- R1: Address decode uses bits [7:4] as group and [3:2] as register (bits [1:0] ignored). Group 0 holds mask (0x00), raw (0x04), masked (0x08) and clear (0x0C). Group n+1 holds channel n: load (+0x0), count (+0x4), control (+0x8), background load (+0xC). Any other address reads zero and a write to it changes nothing.
- R2: A load write sets both the count and the reload value of that channel. A background-load write sets only the reload value, and the count carries on undisturbed. Both load and background-load offsets read back the reload value.
- R3: Control bits [3:2] choose the step rate: 00 steps on every tick_en pulse, 01 on every 16th, and 10 or 11 on every 256th. The pulse counter of a channel restarts from zero on any control write to that channel. A control write makes no step in its own cycle.
- R4: Control bit 7 enables the channel. A disabled channel never changes its count except through a load write. A load write in the same cycle as a step wins, and the step is dropped.
- R5: A step from a count of 1 (in the selected width) to 0 sets raw status bit n in the following cycle.
- R6: Periodic mode (bit 6 set) changes a count that is already zero, on the next step, to the reload value.
- R7: Free-running mode (bit 6 clear) changes a count that is already zero, on the next step, to all ones of the selected width.
- R8: One-shot mode (bit 0 set) clears control bit 7 on the step that reaches zero, so the channel halts at zero. Only control bits 7, 6, 3, 2, 1 and 0 are stored; the rest read zero.
- R9: With control bit 1 clear, only count bits [15:0] decrement, wrap and reload, and zero detection looks only at them. Bits [31:16] hold their value during steps.
- R10: Masked status reads raw AND mask. The irq output is high exactly when any masked bit is set.
- R11: Writing the clear register clears every raw bit written as one. A channel setting its bit in the same cycle keeps that bit set. The clear register reads zero.
- R12: Raw and masked status are read-only, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count pulse, one tick per high cycle |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, captured at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | OR of all masked status bits |

## Verification
A corrupted count register shows up on the very next read of that channel's count offset. If nothing reads it, the error shows at the next zero crossing, where the raw bit and irq rise a different number of cycles later than the model predicts. A prescaler phase error takes longer to surface: up to 256 ticks can pass before the step sequence differs from the model. A stuck mask or raw bit shows on irq in the same cycle. The bench polls every address in rotation while the model runs, so a divergence in any stored field shows within about twenty cycles.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int unsigned CTL_EN    = 7;
  localparam int unsigned CTL_PER   = 6;
  localparam int unsigned CTL_PS_HI = 3;
  localparam int unsigned CTL_PS_LO = 2;
  localparam int unsigned CTL_WIDE  = 1;
  localparam int unsigned CTL_ONE   = 0;
  localparam logic [7:0]  CTL_KEEP  = 8'hCF;

  localparam logic [1:0] SH_MASK = 2'd0;
  localparam logic [1:0] SH_RAW  = 2'd1;
  localparam logic [1:0] SH_MSK  = 2'd2;
  localparam logic [1:0] SH_CLR  = 2'd3;

  localparam logic [1:0] CH_LOAD = 2'd0;
  localparam logic [1:0] CH_CNT  = 2'd1;
  localparam logic [1:0] CH_CTL  = 2'd2;
  localparam logic [1:0] CH_BG   = 2'd3;

  function automatic logic [7:0] ps_limit(input logic [1:0] code);
    case (code)
      2'b00:   ps_limit = 8'd0;
      2'b01:   ps_limit = 8'd15;
      default: ps_limit = 8'd255;
    endcase
  endfunction
endpackage

// File: rtl/qdt_prescale.sv
module qdt_prescale
  import qdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] code,
  input  logic       tick_en,
  output logic       step
);
  logic [7:0] pc_q, pc_d;
  logic       at_lim;

  always_comb begin
    at_lim = (pc_q == ps_limit(code));
    pc_d   = pc_q;
    step   = 1'b0;
    if (restart) begin
      pc_d = '0;
    end else if (run && tick_en) begin
      if (at_lim) begin
        pc_d = '0;
        step = 1'b1;
      end else begin
        pc_d = pc_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assert_step_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (tick_en && run && !restart));
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ld_we,
  input  logic             bg_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cur_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [7:0]       ctl_o,
  output logic             hit_o
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [CNT_W-1:0] cur_q, cur_d, rld_q, rld_d;
  logic [7:0]       ctl_q, ctl_d;
  logic             step, advance, narrow, is_zero, is_one;
  logic [CNT_W-1:0] view, dec_val, wrap_src, wrap_val;

  qdt_prescale u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_q[CTL_EN]),
    .restart (ctl_we),
    .code    (ctl_q[CTL_PS_HI:CTL_PS_LO]),
    .tick_en (tick_en),
    .step    (step)
  );

  always_comb begin
    narrow   = !ctl_q[CTL_WIDE];
    view     = narrow ? {{(CNT_W-HALF){1'b0}}, cur_q[HALF-1:0]} : cur_q;
    is_zero  = (view == '0);
    is_one   = (view == CNT_W'(1));
    dec_val  = narrow ? {cur_q[CNT_W-1:HALF], cur_q[HALF-1:0] - HALF'(1)}
                      : cur_q - CNT_W'(1);
    wrap_src = ctl_q[CTL_PER] ? rld_q : '1;
    wrap_val = narrow ? {cur_q[CNT_W-1:HALF], wrap_src[HALF-1:0]} : wrap_src;
    advance  = step && !ld_we;

    cur_d = cur_q;
    rld_d = rld_q;
    ctl_d = ctl_q;
    if (advance) begin
      cur_d = is_zero ? wrap_val : dec_val;
      if (is_one && ctl_q[CTL_ONE]) ctl_d[CTL_EN] = 1'b0;
    end
    if (ld_we) begin
      cur_d = wdata;
      rld_d = wdata;
    end
    if (bg_we)  rld_d = wdata;
    if (ctl_we) ctl_d = wdata[7:0] & CTL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      cur_q <= cur_d;
      rld_q <= rld_d;
      ctl_q <= ctl_d;
    end
  end

  assign cur_o = cur_q;
  assign rld_o = rld_q;
  assign ctl_o = ctl_q;
  assign hit_o = advance && is_one;

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_EN] && !ld_we) |=> $stable(cur_q));

  assert_upper_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_we && !ctl_q[CTL_WIDE]) |=> (cur_q[CNT_W-1:HALF] == $past(cur_q[CNT_W-1:HALF])));

  assert_oneshot_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ctl_q[CTL_ONE] && !ctl_we) |=> !ctl_q[CTL_EN]);
endmodule

// File: rtl/qdt_irqctl.sv
module qdt_irqctl #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mask_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] set_i,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] raw_o,
  output logic           irq_o
);
  logic [NCH-1:0] mask_q, mask_d, raw_q, raw_d, clr_bits;

  always_comb begin
    clr_bits = clr_we ? wbits : '0;
    raw_d    = (raw_q & ~clr_bits) | set_i;
    mask_d   = mask_we ? wbits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_q;
  assign irq_o  = |(raw_q & mask_q);

  assert_set_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));

  assert_clear_works_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw_q & $past(wbits & ~set_i)) == '0));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/quad_dtimer.sv
module quad_dtimer
  import qdt_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int unsigned GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grp;
  logic [1:0]       sel;
  logic             shared;
  logic [NCH-1:0]   ch_sel, hit, mask, raw;
  logic [CNT_W-1:0] cur [NCH];
  logic [CNT_W-1:0] rld [NCH];
  logic [7:0]       ctl [NCH];

  assign grp    = bus_addr[ADDR_W-1:4];
  assign sel    = bus_addr[3:2];
  assign shared = (grp == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_sel[i] = (grp == GRP_W'(i + 1));
    qdt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .ld_we   (bus_we && ch_sel[i] && sel == CH_LOAD),
      .bg_we   (bus_we && ch_sel[i] && sel == CH_BG),
      .ctl_we  (bus_we && ch_sel[i] && sel == CH_CTL),
      .wdata   (bus_wdata),
      .cur_o   (cur[i]),
      .rld_o   (rld[i]),
      .ctl_o   (ctl[i]),
      .hit_o   (hit[i])
    );
  end

  qdt_irqctl #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (bus_we && shared && sel == SH_MASK),
    .clr_we  (bus_we && shared && sel == SH_CLR),
    .wbits   (bus_wdata[NCH-1:0]),
    .set_i   (hit),
    .mask_o  (mask),
    .raw_o   (raw),
    .irq_o   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (shared) begin
      case (sel)
        SH_MASK: bus_rdata = CNT_W'(mask);
        SH_RAW:  bus_rdata = CNT_W'(raw);
        SH_MSK:  bus_rdata = CNT_W'(raw & mask);
        default: bus_rdata = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[i]) begin
        case (sel)
          CH_CNT:  bus_rdata = cur[i];
          CH_CTL:  bus_rdata = CNT_W'(ctl[i]);
          default: bus_rdata = rld[i];
        endcase
      end
    end
  end

  assert_unused_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!shared && ch_sel == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_quad_dtimer.sv
`timescale 1ns/1ps
module tb_quad_dtimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  quad_dtimer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int tick_mode = 0;

  // Behavioural reference state
  logic [31:0] m_cur [4];
  logic [31:0] m_rld [4];
  logic [7:0]  m_ctl [4];
  int          m_psc [4];
  logic [3:0]  m_mask, m_raw;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int g = a[7:4];
    int s = a[3:2];
    if (g == 0) begin
      if (s == 0) return {28'd0, m_mask};
      if (s == 1) return {28'd0, m_raw};
      if (s == 2) return {28'd0, m_raw & m_mask};
      return 32'd0;
    end
    if (g >= 1 && g <= 4) begin
      if (s == 1) return m_cur[g-1];
      if (s == 2) return {24'd0, m_ctl[g-1]};
      return m_rld[g-1];
    end
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    int g = a[7:4];
    int s = a[3:2];
    if (g == 0) return (s == 0) ? "R10" : (s == 1) ? "R5/R12" : (s == 2) ? "R10" : "R11";
    if (g > 4) return "R1";
    if (s == 1) return "R3/R4/R6/R7/R9";
    if (s == 2) return "R8";
    return "R2";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cur[c] = '0; m_rld[c] = '0; m_ctl[c] = '0; m_psc[c] = 0;
      end
      m_mask = '0; m_raw = '0;
    end else begin
      logic [3:0] sets;
      int g, s, lim;
      g = bus_addr[7:4];
      s = bus_addr[3:2];
      sets = '0;
      for (int c = 0; c < 4; c++) begin
        logic cw, lw, bw, stp;
        logic [31:0] v, src;
        cw = bus_we && g == c + 1 && s == 2;
        lw = bus_we && g == c + 1 && s == 0;
        bw = bus_we && g == c + 1 && s == 3;
        lim = (m_ctl[c][3:2] == 0) ? 1 : (m_ctl[c][3:2] == 1) ? 16 : 256;
        stp = 1'b0;
        if (cw) m_psc[c] = 0;
        else if (m_ctl[c][7] && tick_en) begin
          if (m_psc[c] == lim - 1) begin m_psc[c] = 0; stp = 1'b1; end
          else m_psc[c] = m_psc[c] + 1;
        end
        if (stp && !lw) begin
          if (m_ctl[c][1]) begin
            v = m_cur[c];
            if (v == 0) m_cur[c] = m_ctl[c][6] ? m_rld[c] : 32'hFFFF_FFFF;
            else m_cur[c] = v - 1;
          end else begin
            v = {16'd0, m_cur[c][15:0]};
            src = m_ctl[c][6] ? m_rld[c] : 32'hFFFF_FFFF;
            if (v == 0) m_cur[c][15:0] = src[15:0];
            else m_cur[c][15:0] = m_cur[c][15:0] - 16'd1;
          end
          if (v == 1) begin
            sets[c] = 1'b1;
            if (m_ctl[c][0]) m_ctl[c][7] = 1'b0;
          end
        end
        if (lw) begin m_cur[c] = bus_wdata; m_rld[c] = bus_wdata; end
        if (bw) m_rld[c] = bus_wdata;
        if (cw) m_ctl[c] = bus_wdata[7:0] & 8'hCF;
      end
      if (bus_we && g == 0 && s == 3) m_raw = m_raw & ~bus_wdata[3:0];
      m_raw = m_raw | sets;
      if (bus_we && g == 0 && s == 0) m_mask = bus_wdata[3:0];
    end
  end

  // Compare on every clock, half a period after the edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 1) begin
      logic [31:0] exp_rd;
      logic        exp_irq;
      exp_rd  = m_read(bus_addr);
      exp_irq = |(m_raw & m_mask);
      vectors++;
      if (bus_rdata !== exp_rd) begin
        miscompares++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h cycle %0d",
                 tag_of(bus_addr), bus_addr, bus_rdata, exp_rd, cyc);
      end
      vectors++;
      if (irq !== exp_irq) begin
        miscompares++;
        $display("FAIL R10 irq actual=%0b expected=%0b cycle %0d", irq, exp_irq, cyc);
      end
    end
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<=150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  int poll_idx = 0;

  task automatic drive_tick();
    tick_en = (tick_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    drive_tick();
  endtask

  // Idle cycles, rotating reads over every address plus unused ones
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      bus_we = 1'b0;
      poll_idx = (poll_idx + 1) % 22;
      bus_addr = (poll_idx < 20) ? 8'(poll_idx * 4) : (poll_idx == 20 ? 8'h60 : 8'hFC);
      drive_tick();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(25);                         // reset state of all registers (R1)
    wr(8'h00, 32'hF);                 // R10: unmask all
    // R7/R4: ch0 free-running, 32-bit, divide by 1
    wr(8'h10, 32'd5);
    wr(8'h18, 32'h82);
    idle(30);
    // R8/R3: ch1 one-shot, divide by 16
    wr(8'h20, 32'd40);
    wr(8'h28, 32'h87);
    idle(700);
    // R9/R6/R2: ch2 periodic, 16-bit, reload changed via background load
    wr(8'h30, 32'h1234_0003);
    wr(8'h38, 32'hC0);
    idle(12);
    wr(8'h3C, 32'h0000_0007);
    idle(40);
    // R3 with sparse ticks: ch3 periodic 32-bit divide by 256, code 11
    tick_mode = 1;
    wr(8'h40, 32'd2);
    wr(8'h48, 32'hCE);
    idle(2400);
    // R11: clears, including a W1C overlap with running channels
    wr(8'h0C, 32'h5);
    idle(8);
    wr(8'h0C, 32'hF);
    idle(8);
    // R12: writes to raw and masked are ignored
    wr(8'h04, 32'hF);
    wr(8'h08, 32'h0);
    idle(8);
    // R1: unused addresses and stored-bit filtering in control
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h1234_5678);
    wr(8'h18, 32'hFF);
    idle(30);
    // R10: partial mask
    wr(8'h00, 32'h2);
    idle(60);
    // R4: park ch0 then ch2, with a load during disable
    tick_mode = 0;
    wr(8'h18, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h38, 32'h02);
    idle(40);
    // R6: load colliding with steps on ch0 at divide by 1
    wr(8'h18, 32'hC2);
    for (int k = 0; k < 6; k++) wr(8'h10, 32'd1);
    idle(30);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule